// File: doc/BRIEF.md
# Conversion Result Store with Ping-Pong Halves

This block holds the results of an analog-to-digital converter until software reads them. A converter writes each 10-bit result with a one-cycle strobe. The block places results in a 16-entry memory at successive addresses. It counts completed acquire/convert sequences and raises an interrupt flag and a done flag once the programmed number of sequences has finished. Software reads any entry through an address port. Each read returns a 16-bit word, either right-justified or left-justified. The read side cannot change the stored contents.

In split mode the memory acts as two 8-entry halves. Each interrupt moves writes to the other half, so software can empty one half while the converter fills the other. A status output names the half being filled. A configuration check reports when channels per sequence times sequences per interrupt exceeds the size of the active region. Even with such a configuration, writes wrap inside the active region and never leave it.

Top module: `adc_result_store`

## Requirements
- R1: After reset, `irq_flag`, `done_flag` and `fill_half` are 0, the write position is entry 0, and every entry reads as 0.
- R2: Each cycle with `res_wr` high stores `res_data` at the current write position, which then advances by one. Entries are read only through `rd_addr`/`rd_data`.
- R3: The interrupt event falls on the `seq_done` pulse that completes `per_irq`+1 sequences (`per_irq`=0 means 1 sequence, 7 means 8). On that event `irq_flag` and `done_flag` are set and the sequence count restarts.
- R4: With `split_en`=0, the write position returns to entry 0 after each interrupt event, and `fill_half` stays 0.
- R5: With `split_en`=1, each interrupt event switches filling to the other half and sets the write position to that half's base (entry 0 for half 0, entry 8 for half 1). `fill_half` shows the half being filled.
- R6: With `split_en`=1, the write position wraps inside the current half (entry 7 is followed by entry 0, entry 15 by entry 8). It never crosses into the other half.
- R7: `cfg_err` is 1 exactly when (`per_irq`+1) × channels exceeds 16 (`split_en`=0) or 8 (`split_en`=1). The channel count is coded on `ch_sel` as 00→1, 01→2, 1x→4.
- R8: With `fmt_left`=0, `rd_data` is the 10-bit entry in bits 9:0 with zeros above. With `fmt_left`=1, the entry is in bits 15:6 with zeros below.
- R9: `irq_clr` clears `irq_flag` and leaves `done_flag` unchanged. `acq_start` clears `done_flag`.
- R10: When an interrupt event coincides with `irq_clr` or `acq_start`, the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_data | input | 10 | Conversion result |
| res_wr | input | 1 | Result write strobe |
| seq_done | input | 1 | One acquire/convert sequence completed |
| acq_start | input | 1 | New acquisition starts; clears done |
| per_irq | input | 4 | Sequences per interrupt minus one |
| ch_sel | input | 2 | Channels per sequence code |
| split_en | input | 1 | Two alternating 8-entry halves |
| fmt_left | input | 1 | Left-justified read format |
| irq_clr | input | 1 | Software clear of the interrupt flag |
| rd_addr | input | 4 | Read entry address |
| rd_data | output | 16 | Formatted entry |
| irq_flag | output | 1 | Interrupt flag |
| done_flag | output | 1 | Done flag |
| fill_half | output | 1 | Half being filled in split mode |
| cfg_err | output | 1 | Conversions per interrupt exceed the region |

## Verification
The bench uses the default parameters: a 16-entry store, 10-bit results and 16-bit reads. With 8-entry halves, nine writes are enough to reach the wrap point of a half, and an interval of two sequences is enough to show the halves alternating. The 4-bit interval field lets a table hit every limit of the configuration check on both sides, in normal and split modes.

// File: rtl/adc_result_store.sv
module adc_result_store #(
  parameter int RES_W = 10,
  parameter int OUT_W = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RES_W-1:0] res_data,
  input  logic             res_wr,
  input  logic             seq_done,
  input  logic             acq_start,
  input  logic [AW-1:0]    per_irq,
  input  logic [1:0]       ch_sel,
  input  logic             split_en,
  input  logic             fmt_left,
  input  logic             irq_clr,
  input  logic [AW-1:0]    rd_addr,
  output logic [OUT_W-1:0] rd_data,
  output logic             irq_flag,
  output logic             done_flag,
  output logic             fill_half,
  output logic             cfg_err
);
  localparam int HALF = DEPTH / 2;
  localparam int PAD  = OUT_W - RES_W;
  localparam int TW   = AW + 3;

  logic [RES_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, seq_cnt, wnext;
  logic [RES_W-1:0] word;
  logic [TW-1:0]    chans, total, limit;
  logic             evt;

  assign evt = seq_done && (seq_cnt == per_irq);

  always_comb begin
    if (split_en) wnext = {wptr[AW-1], wptr[AW-2:0] + 1'b1};
    else          wnext = wptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (res_wr) begin
      mem[wptr] <= res_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      seq_cnt   <= '0;
      fill_half <= 1'b0;
    end else if (evt) begin
      seq_cnt   <= '0;
      fill_half <= split_en ? ~fill_half : 1'b0;
      wptr      <= (split_en && !fill_half) ? AW'(HALF) : '0;
    end else begin
      if (seq_done) seq_cnt <= seq_cnt + 1'b1;
      if (res_wr)   wptr    <= wnext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_flag  <= 1'b0;
      done_flag <= 1'b0;
    end else begin
      if (evt)            irq_flag <= 1'b1;
      else if (irq_clr)   irq_flag <= 1'b0;
      if (evt)            done_flag <= 1'b1;
      else if (acq_start) done_flag <= 1'b0;
    end
  end

  assign word    = mem[rd_addr];
  assign rd_data = fmt_left ? {word, {PAD{1'b0}}} : {{PAD{1'b0}}, word};

  assign chans   = (ch_sel == 2'b00) ? TW'(1) : (ch_sel == 2'b01) ? TW'(2) : TW'(4);
  assign total   = (TW'(per_irq) + TW'(1)) * chans;
  assign limit   = split_en ? TW'(HALF) : TW'(DEPTH);
  assign cfg_err = total > limit;
endmodule

module adc_result_store_chk #(
  parameter int OUT_W = 16,
  parameter int RES_W = 10,
  parameter int AW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             seq_done,
  input logic             acq_start,
  input logic             irq_clr,
  input logic             split_en,
  input logic             fmt_left,
  input logic [AW-1:0]    per_irq,
  input logic [OUT_W-1:0] rd_data,
  input logic             irq_flag,
  input logic             done_flag,
  input logic             fill_half,
  input logic             cfg_err
);
  localparam int PAD = OUT_W - RES_W;

  p_irq_from_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(seq_done));
  p_done_from_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(seq_done));
  p_half_moves_on_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fill_half) |-> $past(seq_done));
  p_irq_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);
  p_done_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_flag) |-> $past(acq_start));
  p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_flag) |-> $past(irq_clr));
  p_split_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (split_en && per_irq[AW-1]) |-> cfg_err);
  p_left_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_left |-> (rd_data[PAD-1:0] == '0));
  p_right_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt_left |-> (rd_data[OUT_W-1:RES_W] == '0));
endmodule

bind adc_result_store adc_result_store_chk #(.OUT_W(OUT_W), .RES_W(RES_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .seq_done(seq_done), .acq_start(acq_start),
  .irq_clr(irq_clr), .split_en(split_en), .fmt_left(fmt_left), .per_irq(per_irq),
  .rd_data(rd_data), .irq_flag(irq_flag), .done_flag(done_flag),
  .fill_half(fill_half), .cfg_err(cfg_err)
);

// File: tb/adc_result_store_tb.sv
module adc_result_store_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  res_data = '0;
  logic        res_wr = 1'b0, seq_done = 1'b0, acq_start = 1'b0;
  logic [3:0]  per_irq = '0;
  logic [1:0]  ch_sel = '0;
  logic        split_en = 1'b0, fmt_left = 1'b0, irq_clr = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq_flag, done_flag, fill_half, cfg_err;
  int          n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  adc_result_store u_dut (
    .clk(clk), .rst_n(rst_n), .res_data(res_data), .res_wr(res_wr),
    .seq_done(seq_done), .acq_start(acq_start), .per_irq(per_irq),
    .ch_sel(ch_sel), .split_en(split_en), .fmt_left(fmt_left),
    .irq_clr(irq_clr), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_flag(irq_flag), .done_flag(done_flag), .fill_half(fill_half),
    .cfg_err(cfg_err)
  );

  // {split_en, ch_sel, per_irq, expected cfg_err}
  localparam logic [7:0] CFG_VEC [12] = '{
    {1'b0, 2'd0, 4'd15, 1'b0}, {1'b0, 2'd1, 4'd7, 1'b0}, {1'b0, 2'd1, 4'd8, 1'b1},
    {1'b0, 2'd2, 4'd3, 1'b0},  {1'b0, 2'd3, 4'd4, 1'b1}, {1'b1, 2'd0, 4'd7, 1'b0},
    {1'b1, 2'd0, 4'd8, 1'b1},  {1'b1, 2'd1, 4'd3, 1'b0}, {1'b1, 2'd1, 4'd4, 1'b1},
    {1'b1, 2'd2, 4'd1, 1'b0},  {1'b1, 2'd2, 4'd2, 1'b1}, {1'b0, 2'd3, 4'd0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rdchk(input string tag, input int a, input logic fl, input logic [15:0] exp);
    rd_addr = 4'(a);
    fmt_left = fl;
    #1;
    chk(tag, 32'(rd_data), 32'(exp));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [9:0] v);
    @(negedge clk); res_wr = 1'b1; res_data = v;
    @(negedge clk); res_wr = 1'b0;
  endtask

  task automatic seq(input logic clr, input logic acq);
    @(negedge clk); seq_done = 1'b1; irq_clr = clr; acq_start = acq;
    @(negedge clk); seq_done = 1'b0; irq_clr = 1'b0; acq_start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1 irq after reset", 32'(irq_flag), 0);
    chk("R1 done after reset", 32'(done_flag), 0);
    chk("R1 half after reset", 32'(fill_half), 0);
    for (int a = 0; a < 16; a++) rdchk("R1 entry zero", a, 1'b0, 16'h0000);

    for (int i = 0; i < 12; i++) begin
      split_en = CFG_VEC[i][7];
      ch_sel   = CFG_VEC[i][6:5];
      per_irq  = CFG_VEC[i][4:1];
      #1;
      chk("R7 cfg_err", 32'(cfg_err), 32'(CFG_VEC[i][0]));
    end

    // Normal mode, 3 sequences per interrupt
    do_reset();
    split_en = 1'b0; per_irq = 4'd2; ch_sel = 2'd0;
    wr(10'h101); seq(0, 0);
    wr(10'h202); seq(0, 0);
    chk("R3 no irq before count", 32'(irq_flag), 0);
    wr(10'h303); seq(0, 0);
    chk("R3 irq at count", 32'(irq_flag), 1);
    chk("R3 done at count", 32'(done_flag), 1);
    chk("R4 half stays 0", 32'(fill_half), 0);
    rdchk("R2 entry0", 0, 1'b0, 16'h0101);
    rdchk("R2 entry1", 1, 1'b0, 16'h0202);
    rdchk("R2 entry2", 2, 1'b0, 16'h0303);
    wr(10'h3FF);
    rdchk("R4 pointer back to 0", 0, 1'b0, 16'h03FF);
    rdchk("R4 entry1 kept", 1, 1'b0, 16'h0202);
    rdchk("R8 left format", 0, 1'b1, 16'hFFC0);
    rdchk("R8 left format b", 2, 1'b1, 16'hC0C0);

    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk("R9 irq cleared", 32'(irq_flag), 0);
    chk("R9 done kept", 32'(done_flag), 1);
    @(negedge clk); acq_start = 1'b1;
    @(negedge clk); acq_start = 1'b0;
    chk("R9 done cleared", 32'(done_flag), 0);

    per_irq = 4'd0;
    seq(1, 1);
    chk("R10 irq set wins", 32'(irq_flag), 1);
    chk("R10 done set wins", 32'(done_flag), 1);

    // Split mode, 2 sequences per interrupt
    do_reset();
    split_en = 1'b1; per_irq = 4'd1;
    wr(10'h011); wr(10'h022); seq(0, 0);
    chk("R5 half 0 before event", 32'(fill_half), 0);
    seq(0, 0);
    chk("R5 half 1 after event", 32'(fill_half), 1);
    wr(10'h0AA); wr(10'h0BB);
    rdchk("R5 fill entry8", 8, 1'b0, 16'h00AA);
    rdchk("R5 fill entry9", 9, 1'b0, 16'h00BB);
    rdchk("R5 entry0 kept", 0, 1'b0, 16'h0011);
    seq(0, 0); seq(0, 0);
    chk("R5 half back to 0", 32'(fill_half), 0);
    wr(10'h0CC);
    rdchk("R5 refill entry0", 0, 1'b0, 16'h00CC);
    rdchk("R5 entry1 kept", 1, 1'b0, 16'h0022);

    // Split wrap within half 0
    do_reset();
    split_en = 1'b1; per_irq = 4'd7;
    for (int i = 0; i < 9; i++) wr(10'h010 + 10'(i));
    rdchk("R6 wrap to entry0", 0, 1'b0, 16'h0018);
    rdchk("R6 entry7", 7, 1'b0, 16'h0017);
    rdchk("R6 entry8 untouched", 8, 1'b0, 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule